// File: doc/BRIEF.md
# Sticky Error Code Aggregator

This block gathers error pulses from a bank of FIFOs and from a set of state-machine and counter checkers into a single 32-bit sticky error code word. Each FIFO reports three kinds of fault: a write while full, a read while empty, and a state showing empty and full together. The word keeps one source bit per FIFO plus three type bits that all FIFOs share, so software can tell which FIFO failed and which kind of fault happened. The checker pulses land in their own bits. Once set, every bit stays set until reset.

Any recorded error drives a fatal alert level. Error events from the FIFO source positions or the checker positions also set a fatal interrupt state bit. That bit has an enable, a write-1-to-clear state and a test register. An injection register takes a bit number and fires one error pulse at that position, so that the path to the alert and the interrupt can be tested. Injection is accepted only while a global write-enable bit is set. That bit starts at 1 and can only be cleared.

The register port is a simple single-cycle write strobe with word address and combinational read data. Word addresses: 0 error code (read only), 1 injection bit number (bits 4:0), 2 write-enable (bit 0), 3 interrupt state (bit 0), 4 interrupt enable (bit 0), 5 interrupt test (bit 0, write only, reads 0).

Top module: `sticky_err_agg`

## Requirements
- R1: FIFO k drives `fifo_err_i[3k]` (write while full), `fifo_err_i[3k+1]` (read while empty) and `fifo_err_i[3k+2]` (empty and full at once). Any of these bits high sets code bit k, visible from the clock edge that samples the pulse.
- R2: Code bit 28 is the OR of all FIFOs' write-while-full inputs, bit 29 the OR of all read-while-empty inputs, and bit 30 the OR of all empty-and-full inputs.
- R3: Checker input `chk_err_i[i]` (i = 0..6) sets code bit 20+i.
- R4: Every code bit stays set until reset. It is 0 after reset, and writes to address 0 do not change it.
- R5: Bits 16 to 19, 27 and 31 always read 0, including after an injection that names one of them. The valid mask is 0x77F0FFFF.
- R6: A write of n to address 1 while the write-enable bit is 1 sets code bit n at that clock edge and stores n for readback. While the write-enable bit is 0, the write has no effect.
- R7: `fatal_alert_o` is high whenever any code bit is set, and low otherwise.
- R8: A FIFO or checker pulse, or an injection at bits 0-15 or 20-26, sets interrupt state bit 0. An injection only at bits 28-30 does not set it. Writing 1 to address 3 clears the bit, and a new set event in the same cycle wins. Writing 1 to address 5 sets it. `fatal_irq_o` equals state AND enable (address 4 bit 0).
- R9: The write-enable bit (address 2, bit 0) is 1 after reset. Writing 0 clears it, and writing 1 never sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_err_i | input | 3*NFIFO (48) | Per-FIFO error pulses, three per FIFO |
| chk_err_i | input | NCHK (7) | Checker error pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW (3) | Register word address |
| reg_wdata_i | input | DW (32) | Register write data |
| reg_rdata_o | output | DW (32) | Register read data for `reg_addr_i` |
| fatal_alert_o | output | 1 | Fatal alert level |
| fatal_irq_o | output | 1 | Fatal interrupt |

## Verification
A vector table drives single pulses into the first FIFO, the last FIFO and a middle FIFO with each fault type. It also drives one FIFO with all three types at once, two FIFOs with different types in the same cycle, single and all checkers, and an idle vector. These cases separate a swapped source index, a swapped type column and a misplaced checker offset. Directed sequences then cover several things: accumulation over separate pulses, the irrelevance of writes to the code word, interrupt clear, test and enable gating, and injection at a checker position, a reserved position and a type-only position. The last two show that the alert and the interrupt state follow different masks. A locked write-enable must stop injection and must not be set again.

// File: rtl/sticky_err_agg.sv
module sticky_err_agg #(
  parameter int NFIFO    = 16,
  parameter int NCHK     = 7,
  parameter int DW       = 32,
  parameter int AW       = 3,
  parameter int CHK_LSB  = 20,
  parameter int TYPE_LSB = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3*NFIFO-1:0]   fifo_err_i,
  input  logic [NCHK-1:0]      chk_err_i,
  input  logic                 reg_we_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  output logic                 fatal_alert_o,
  output logic                 fatal_irq_o
);
  localparam int IDXW = $clog2(DW);
  localparam logic [AW-1:0] A_CODE = AW'(0);
  localparam logic [AW-1:0] A_INJ  = AW'(1);
  localparam logic [AW-1:0] A_WEN  = AW'(2);
  localparam logic [AW-1:0] A_IST  = AW'(3);
  localparam logic [AW-1:0] A_IEN  = AW'(4);
  localparam logic [AW-1:0] A_ITST = AW'(5);
  localparam logic [DW-1:0] SRC_MASK   = DW'((64'd1 << NFIFO) - 64'd1);
  localparam logic [DW-1:0] CHK_MASK   = DW'(((64'd1 << NCHK) - 64'd1) << CHK_LSB);
  localparam logic [DW-1:0] TYPE_MASK  = DW'(64'd7 << TYPE_LSB);
  localparam logic [DW-1:0] FATAL_MASK = SRC_MASK | CHK_MASK;
  localparam logic [DW-1:0] VALID_MASK = FATAL_MASK | TYPE_MASK;

  logic [NFIFO-1:0] src;
  logic [2:0]       typ;
  logic [DW-1:0]    code_q, inj_vec, ev_vec;
  logic [IDXW-1:0]  inj_q;
  logic             wen_q, ist_q, ien_q;
  logic             unused_wdata;

  for (genvar k = 0; k < NFIFO; k++) begin : g_src
    assign src[k] = |fifo_err_i[3*k +: 3];
  end

  always_comb begin
    typ = '0;
    for (int k = 0; k < NFIFO; k++) typ = typ | fifo_err_i[3*k +: 3];
  end

  wire wr_inj  = reg_we_i && (reg_addr_i == A_INJ) && wen_q;
  wire wr_wen0 = reg_we_i && (reg_addr_i == A_WEN) && !reg_wdata_i[0];
  wire ist_clr = reg_we_i && (reg_addr_i == A_IST) && reg_wdata_i[0];
  wire ist_tst = reg_we_i && (reg_addr_i == A_ITST) && reg_wdata_i[0];

  assign inj_vec = wr_inj ? (DW'(1) << reg_wdata_i[IDXW-1:0]) : '0;
  assign ev_vec  = (DW'(src) | (DW'(chk_err_i) << CHK_LSB) | (DW'(typ) << TYPE_LSB) | inj_vec)
                   & VALID_MASK;
  wire ist_set = (|(ev_vec & FATAL_MASK)) || ist_tst;
  assign unused_wdata = ^reg_wdata_i[DW-1:IDXW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      inj_q  <= '0;
      wen_q  <= 1'b1;
      ist_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      code_q <= code_q | ev_vec;
      if (wr_inj) inj_q <= reg_wdata_i[IDXW-1:0];
      if (wr_wen0) wen_q <= 1'b0;
      ist_q <= ist_set || (ist_q && !ist_clr);
      if (reg_we_i && reg_addr_i == A_IEN) ien_q <= reg_wdata_i[0];
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_CODE:  reg_rdata_o = code_q;
      A_INJ:   reg_rdata_o = DW'(inj_q);
      A_WEN:   reg_rdata_o = DW'(wen_q);
      A_IST:   reg_rdata_o = DW'(ist_q);
      A_IEN:   reg_rdata_o = DW'(ien_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign fatal_alert_o = |code_q;
  assign fatal_irq_o   = ist_q & ien_q;

  // R4: no code bit ever falls outside reset
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((code_q & $past(code_q)) == $past(code_q)));
  // R5: reserved positions stay clear
  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q & ~VALID_MASK) == '0);
  // R7: a FIFO fault leaves the alert raised
  p_alert_after_fifo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|fifo_err_i) |=> fatal_alert_o);
  // R8: any FIFO or checker pulse sets the interrupt state
  p_irq_state_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fifo_err_i) || (|chk_err_i)) |=> ist_q);
  // R9: a cleared write-enable never returns
  p_wen_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_q |=> !wen_q);
  // R6: a locked injection with quiet inputs leaves the code word alone
  p_inject_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == A_INJ && !wen_q && fifo_err_i == '0 && chk_err_i == '0)
      |=> $stable(code_q));
endmodule

// File: tb/sim_sticky_err_agg.sv
module sim_sticky_err_agg;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [47:0] V_FIFO [NV] = '{48'h0000_0000_0001, 48'h4000_0000_0000,
    48'h0000_0002_0000, 48'h0000_0000_0E00, 48'h0, 48'h0, 48'h0000_0220_0000, 48'h0};
  localparam logic [6:0] V_CHK [NV] = '{7'h0, 7'h0, 7'h0, 7'h0, 7'h01, 7'h7F, 7'h0, 7'h0};
  localparam logic [31:0] V_EXP [NV] = '{32'h1000_0001, 32'h2000_8000, 32'h4000_0020,
    32'h7000_0008, 32'h0010_0000, 32'h07F0_0000, 32'h3000_0180, 32'h0};
  localparam logic [2:0] A_CODE = 0, A_INJ = 1, A_WEN = 2, A_IST = 3, A_IEN = 4, A_ITST = 5;

  logic clk = 0, rst_n = 0;
  logic [47:0] fifo_err = '0;
  logic [6:0]  chk_err = '0;
  logic        we = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        alert, irq;
  int nvec = 0, nbad = 0;
  logic [31:0] r;

  sticky_err_agg u0 (.clk(clk), .rst_n(rst_n), .fifo_err_i(fifo_err), .chk_err_i(chk_err),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .fatal_alert_o(alert), .fatal_irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fifo_err = '0; chk_err = '0; we = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [47:0] f, input logic [6:0] c);
    @(negedge clk);
    fifo_err = f; chk_err = c;
    @(negedge clk);
    fifo_err = '0; chk_err = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(A_IEN, 1);
      pulse(V_FIFO[i], V_CHK[i]);
      rd(A_CODE, r); check($sformatf("R1 R2 R3 vector %0d code", i), r, V_EXP[i]);
      check($sformatf("R7 vector %0d alert", i), {31'b0, alert}, {31'b0, V_EXP[i] != 0});
      rd(A_IST, r); check($sformatf("R8 vector %0d irq state", i), r, {31'b0, V_EXP[i] != 0});
      #1 check($sformatf("R8 vector %0d irq out", i), {31'b0, irq}, {31'b0, V_EXP[i] != 0});
    end

    do_reset();
    rd(A_CODE, r); check("R4 reset code", r, 0);
    rd(A_WEN, r);  check("R9 reset write-enable", r, 1);
    rd(A_IST, r);  check("R8 reset irq state", r, 0);
    rd(A_INJ, r);  check("R6 reset inject readback", r, 0);
    check("R7 reset alert", {31'b0, alert}, 0);

    wr(A_IEN, 1);
    pulse(48'h80, 0);
    repeat (5) @(negedge clk);
    rd(A_CODE, r); check("R4 sticky after idle", r, 32'h2000_0004);
    pulse(0, 7'h08);
    rd(A_CODE, r); check("R4 R3 accumulate", r, 32'h2080_0004);
    wr(A_CODE, 0);
    rd(A_CODE, r); check("R4 code write ignored", r, 32'h2080_0004);

    wr(A_IST, 1);
    rd(A_IST, r); check("R8 write-1 clears state", r, 0);
    check("R7 alert holds after irq clear", {31'b0, alert}, 1);
    #1 check("R8 irq low after clear", {31'b0, irq}, 0);
    wr(A_ITST, 1);
    rd(A_IST, r); check("R8 test sets state", r, 1);
    #1 check("R8 irq from test", {31'b0, irq}, 1);
    wr(A_IEN, 0);
    #1 check("R8 irq gated by enable", {31'b0, irq}, 0);

    do_reset();
    wr(A_INJ, 21);
    rd(A_CODE, r); check("R6 inject bit 21", r, 32'h0020_0000);
    rd(A_IST, r);  check("R8 inject checker bit sets state", r, 1);
    rd(A_INJ, r);  check("R6 inject readback", r, 21);

    do_reset();
    wr(A_INJ, 17);
    rd(A_CODE, r); check("R5 inject reserved ignored", r, 0);
    check("R5 alert after reserved inject", {31'b0, alert}, 0);

    do_reset();
    wr(A_INJ, 29);
    rd(A_CODE, r); check("R6 inject bit 29", r, 32'h2000_0000);
    check("R7 alert on type-only bit", {31'b0, alert}, 1);
    rd(A_IST, r); check("R8 type-only inject leaves state", r, 0);

    do_reset();
    wr(A_WEN, 1);
    rd(A_WEN, r); check("R9 write 1 keeps enable", r, 1);
    wr(A_WEN, 0);
    rd(A_WEN, r); check("R9 write 0 clears", r, 0);
    wr(A_WEN, 1);
    rd(A_WEN, r); check("R9 cannot re-set", r, 0);
    wr(A_INJ, 3);
    rd(A_CODE, r); check("R6 locked inject ignored", r, 0);
    rd(A_INJ, r);  check("R6 locked inject readback", r, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule